// File: doc/BRIEF.md
# Four-Channel DAC Register Core with Staged Power-Down

This block is the digital register core behind a four-channel, 16-bit digital-to-analog converter. A parallel write port delivers one update: a control byte plus a high and a low data byte. Each channel keeps two 18-bit registers. The first is a staging (temporary) register. The second is the live DAC register, which drives the output code and the output-stage mode.

In both registers, bits [17:16] hold a power-down code and bits [15:0] hold the sample. A power-down request is just another kind of write. It lands in the staging register and reaches the DAC register under the same load rules as a sample. A single load event can therefore switch one channel off while the other channels take new samples.

Control byte layout with the default parameters:
- bit 0: power-down flag.
- bits [2:1]: channel select.
- bits [4:3]: load action.
- bit 5: broadcast.
- bits [7:6]: ignored.

Top module: `dac_chan_bank`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted write, every channel outputs code 0, mode 00 and active = 1.
- R2: An accepted write with control bit 0 = 0 stores {msb, lsb} as the staging data of the target channel, clears its power-down code to 00 and marks it not powered down.
- R3: An accepted write with control bit 0 = 1 stores msb[7:6] as the target's power-down code, keeps the target's 16 staged data bits and marks it powered down.
- R4: Load action 00 or 11 (control bits [4:3]) writes only the staging register; no DAC register changes.
- R5: Load action 01 writes the staging register and copies it into that same channel's DAC register on the same edge.
- R6: Load action 10 writes the staging register and copies all four staging registers, including the value just written, into their DAC registers on one edge.
- R7: Control bit 5 = 1 (broadcast) writes the same value to every staging register and loads every DAC register, whatever the channel select and load action.
- R8: Each channel's code output is DAC bits [15:0] and its mode output is DAC bits [17:16]. Its active output is 0 exactly when the DAC register holds a power-down entry, and this includes code 00.
- R9: Control bits [2:1] select channel 0 to 3 as the target when broadcast is off.
- R10: When wr_valid is low, no register changes, whatever the other inputs are.
- R11: In one load-all event, one channel can enter power-down with its data intact while the other channels take newly staged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| wr_valid | input | 1 | Accept the write on this edge |
| wr_ctrl | input | 8 | Control byte |
| wr_msb | input | 8 | High data byte; bits [7:6] carry the power-down code |
| wr_lsb | input | 8 | Low data byte |
| out_code | output | 64 | Per-channel 16-bit code, channel i at [16i+15:16i] |
| out_mode | output | 8 | Per-channel output-stage mode, channel i at [2i+1:2i] |
| out_active | output | 4 | Per-channel 1 = running normally, 0 = powered down |

## Verification
A corrupted staging register shows nothing at the outputs until a later load copies it across. The bench therefore follows each staging-only write with load-all and broadcast events, which expose the staged value on the very next clock. A wrong DAC register or a wrong power-down bit changes code, mode or active one cycle after the edge that caused it, and every output is compared after every edge. A lost data word behind a power-down entry becomes visible when the channel is later loaded again, so power-down writes are mixed with data reloads.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  // Load action carried in the control byte.
  typedef enum logic [1:0] {
    LD_STAGE_ONLY = 2'b00,
    LD_SELF       = 2'b01,
    LD_ALL        = 2'b10,
    LD_RESERVED   = 2'b11
  } load_act_e;

  localparam int CTRL_W      = 8;
  localparam int CTRL_PD_BIT = 0;
  localparam int CTRL_SEL_LO = 1;

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dac_ctrl_decode.sv
module dac_ctrl_decode
  import dac_bank_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic              rst_n,
  input  logic              clk,
  input  logic              wr_valid,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [N_CH-1:0]   stage_en,
  output logic [N_CH-1:0]   load_en,
  output logic              pd_req
);

  localparam int SEL_W     = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int LD_LO     = CTRL_SEL_LO + SEL_W;
  localparam int BCAST_BIT = LD_LO + 2;

  logic [SEL_W-1:0] sel;
  load_act_e        act;
  logic             bcast;

  always_comb begin
    sel    = ctrl[CTRL_SEL_LO +: SEL_W];
    act    = load_act_e'(ctrl[LD_LO +: 2]);
    bcast  = ctrl[BCAST_BIT];
    pd_req = ctrl[CTRL_PD_BIT];
    for (int i = 0; i < N_CH; i++) begin
      stage_en[i] = wr_valid && (bcast || (sel == SEL_W'(i)));
      load_en[i]  = wr_valid && (bcast || (act == LD_ALL) ||
                                 ((act == LD_SELF) && (sel == SEL_W'(i))));
    end
  end

  // Broadcast stages every channel.
  assert_bcast_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && bcast) |-> (&stage_en && &load_en));

  // Idle port enables nothing.
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (stage_en == '0 && load_en == '0));

  // Without broadcast at most one channel is staged.
  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !bcast) |-> $countones(stage_en) == 1);

endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int DATA_W = 16,
  parameter int PD_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_en,
  input  logic              load_en,
  input  logic              pd_req,
  input  logic [PD_W-1:0]   pd_code,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] code,
  output logic [PD_W-1:0]   mode,
  output logic              active
);

  localparam int REG_W = PD_W + DATA_W;

  logic [REG_W-1:0] stg_q, stg_d;
  logic             stg_pd_q, stg_pd_d;
  logic [REG_W-1:0] live_q, live_d;
  logic             live_pd_q, live_pd_d;

  always_comb begin
    stg_d    = stg_q;
    stg_pd_d = stg_pd_q;
    if (stage_en) begin
      if (pd_req) begin
        stg_d    = {pd_code, stg_q[DATA_W-1:0]};
        stg_pd_d = 1'b1;
      end else begin
        stg_d    = {{PD_W{1'b0}}, wdata};
        stg_pd_d = 1'b0;
      end
    end
    live_d    = stg_d;
    live_pd_d = stg_pd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q    <= '0;
      stg_pd_q <= 1'b0;
    end else if (stage_en) begin
      stg_q    <= stg_d;
      stg_pd_q <= stg_pd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q    <= '0;
      live_pd_q <= 1'b0;
    end else if (load_en) begin
      live_q    <= live_d;
      live_pd_q <= live_pd_d;
    end
  end

  assign code   = live_q[DATA_W-1:0];
  assign mode   = live_q[REG_W-1:DATA_W];
  assign active = ~live_pd_q;

  // A running channel never carries a power-down code.
  assert_run_mode_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (mode == '0));

  // Normal write lands the new word in staging.
  assert_stage_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en && !pd_req) |=> (stg_q[DATA_W-1:0] == $past(wdata) && !stg_pd_q));

  // Power-down write keeps the staged data bits.
  assert_pd_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en && pd_req) |=> ($stable(stg_q[DATA_W-1:0]) && stg_pd_q));

  // Live register holds without a load.
  assert_live_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(live_q) && $stable(live_pd_q)));

  // A loaded channel mirrors staging on the next cycle.
  assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (live_q == stg_q && live_pd_q == stg_pd_q));

endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
  import dac_bank_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DATA_W = 16,
  parameter int PD_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [CTRL_W-1:0]      wr_ctrl,
  input  logic [DATA_W/2-1:0]    wr_msb,
  input  logic [DATA_W/2-1:0]    wr_lsb,
  output logic [N_CH*DATA_W-1:0] out_code,
  output logic [N_CH*PD_W-1:0]   out_mode,
  output logic [N_CH-1:0]        out_active
);

  localparam int BYTE_W = DATA_W / 2;

  logic              rst_n_int;
  logic [N_CH-1:0]   stage_en;
  logic [N_CH-1:0]   load_en;
  logic              pd_req;
  logic [PD_W-1:0]   pd_code;
  logic [DATA_W-1:0] wdata;

  assign pd_code = wr_msb[BYTE_W-1 -: PD_W];
  assign wdata   = {wr_msb, wr_lsb};

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dac_ctrl_decode #(.N_CH(N_CH)) u_dec (
    .rst_n    (rst_n_int),
    .clk      (clk),
    .wr_valid (wr_valid),
    .ctrl     (wr_ctrl),
    .stage_en (stage_en),
    .load_en  (load_en),
    .pd_req   (pd_req)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dac_channel #(.DATA_W(DATA_W), .PD_W(PD_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .stage_en (stage_en[g]),
      .load_en  (load_en[g]),
      .pd_req   (pd_req),
      .pd_code  (pd_code),
      .wdata    (wdata),
      .code     (out_code[g*DATA_W +: DATA_W]),
      .mode     (out_mode[g*PD_W +: PD_W]),
      .active   (out_active[g])
    );
  end

endmodule

// File: tb/dac_chan_bank_test.sv
module dac_chan_bank_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [7:0]  wr_ctrl, wr_msb, wr_lsb;
  logic [63:0] out_code;
  logic [7:0]  out_mode;
  logic [3:0]  out_active;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_sd [4];
  logic [1:0]  m_sm [4];
  logic        m_sp [4];
  logic [15:0] m_ld [4];
  logic [1:0]  m_lm [4];
  logic        m_lp [4];

  always #10 clk = ~clk;

  dac_chan_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ctrl(wr_ctrl),
    .wr_msb(wr_msb), .wr_lsb(wr_lsb), .out_code(out_code),
    .out_mode(out_mode), .out_active(out_active)
  );

  function automatic logic [7:0] mk_ctrl(input bit pd, input int ch,
                                         input int act, input bit bc);
    return {2'b00, bc, 2'(act), 2'(ch), pd};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_sd[i] = '0; m_sm[i] = '0; m_sp[i] = 1'b0;
      m_ld[i] = '0; m_lm[i] = '0; m_lp[i] = 1'b0;
    end
  endtask

  task automatic model_write(input logic [7:0] c, input logic [7:0] hi,
                             input logic [7:0] lo);
    bit pd = c[0];
    int ch = int'(c[2:1]);
    int act = int'(c[4:3]);
    bit bc = c[5];
    for (int i = 0; i < 4; i++) begin
      if (bc || i == ch) begin
        if (pd) begin m_sm[i] = hi[7:6]; m_sp[i] = 1'b1; end
        else begin m_sd[i] = {hi, lo}; m_sm[i] = 2'b00; m_sp[i] = 1'b0; end
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (bc || act == 2 || (act == 1 && i == ch)) begin
        m_ld[i] = m_sd[i]; m_lm[i] = m_sm[i]; m_lp[i] = m_sp[i];
      end
    end
  endtask

  task automatic check_all(input string tag);
    checks++;
    for (int i = 0; i < 4; i++) begin
      if (out_code[i*16 +: 16] !== m_ld[i] || out_mode[i*2 +: 2] !== m_lm[i] ||
          out_active[i] !== ~m_lp[i]) begin
        errors++;
        $display("FAIL %s ch%0d: code=%h mode=%b active=%b expected code=%h mode=%b active=%b",
                 tag, i, out_code[i*16 +: 16], out_mode[i*2 +: 2], out_active[i],
                 m_ld[i], m_lm[i], ~m_lp[i]);
        break;
      end
    end
  endtask

  // Drive at the falling edge, commit at the rising edge, check at the next falling edge.
  task automatic do_write(input logic [7:0] c, input logic [7:0] hi,
                          input logic [7:0] lo, input string tag);
    wr_valid = 1'b1; wr_ctrl = c; wr_msb = hi; wr_lsb = lo;
    @(posedge clk);
    model_write(c, hi, lo);
    @(negedge clk);
    wr_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic do_idle(input logic [7:0] c, input logic [7:0] hi,
                         input logic [7:0] lo);
    wr_valid = 1'b0; wr_ctrl = c; wr_msb = hi; wr_lsb = lo;
    @(posedge clk);
    @(negedge clk);
    check_all("R10 idle port");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    model_reset();
    rst_n = 1'b0; wr_valid = 1'b0; wr_ctrl = '0; wr_msb = '0; wr_lsb = '0;
    repeat (3) @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");

    // R4: staging only, live stays at zero.
    do_write(mk_ctrl(0, 2, 0, 0), 8'hAB, 8'hCD, "R4 stage only");
    do_write(mk_ctrl(0, 2, 3, 0), 8'h11, 8'h22, "R4 reserved action");
    // R5 / R2: self load.
    do_write(mk_ctrl(0, 2, 1, 0), 8'h12, 8'h34, "R5/R2 self load");
    // R3: power-down mode 01 keeps data 1234.
    do_write(mk_ctrl(1, 2, 1, 0), 8'h40, 8'hFF, "R3 pd mode 01");
    // R8: power-down with code 00 still reports inactive.
    do_write(mk_ctrl(0, 1, 1, 0), 8'h77, 8'h88, "R2 load ch1");
    do_write(mk_ctrl(1, 1, 1, 0), 8'h00, 8'h00, "R8 pd code 00");
    // R11 / R6: stage data on ch0 and ch3, then pd ch1 via load-all.
    do_write(mk_ctrl(0, 0, 0, 0), 8'hA0, 8'h01, "R4 stage ch0");
    do_write(mk_ctrl(0, 3, 0, 0), 8'hB0, 8'h03, "R4 stage ch3");
    do_write(mk_ctrl(1, 1, 2, 0), 8'h80, 8'h00, "R11/R6 pd with load-all");
    // R2: a normal write wakes the channel.
    do_write(mk_ctrl(0, 2, 1, 0), 8'h55, 8'h66, "R2 wake ch2");
    // R7: broadcast power-down mode 10 ignores select and action.
    do_write(mk_ctrl(1, 3, 0, 1), 8'h80, 8'h00, "R7 broadcast pd");
    do_write(mk_ctrl(0, 0, 0, 1), 8'hFE, 8'hDC, "R7 broadcast data");
    // R9: each select value targets one channel.
    for (int ch = 0; ch < 4; ch++)
      do_write(mk_ctrl(0, ch, 1, 0), 8'(ch * 16 + 1), 8'(ch), "R9 select");
    // R10: idle port with tempting inputs.
    do_idle(mk_ctrl(1, 0, 2, 1), 8'hC0, 8'h00);
    do_idle(mk_ctrl(0, 3, 1, 0), 8'h99, 8'h99);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] c  = 8'($urandom);
      logic [7:0] hi = 8'($urandom);
      logic [7:0] lo = 8'($urandom);
      c[5] = ($urandom % 8) == 0;
      if (($urandom % 6) == 0) do_idle(c, hi, lo);
      else do_write(c, hi, lo, "R2/R3/R4/R5/R6/R7/R9 random");
    end

    // R1: reset mid-run clears everything.
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    check_all("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after second release");
    do_write(mk_ctrl(0, 1, 1, 0), 8'h3C, 8'hC3, "R5 after reset");

    finish_run();
  end

endmodule